// File: doc/BRIEF.md
# Two-Stage Selectable ADC Sampling Clock Divider

This block derives the sampling clock for a successive-approximation converter from a PLL output clock. The first stage divides by one of six fixed ratios, picked by a 3-bit code: 1, 2, 10, 20, 40 or 80. The second stage divides by 10 or 20. A mode input selects normal conversion or temperature sensing. While temperature sensing is on, a further select decides which stage drives the output clock. In normal mode the first stage always drives it.

Every ratio is even, or is 1, so the divided clock has an exact 50% duty cycle. Ratio 1 passes the input clock straight through. A new setting is taken up only when the current output period ends, so no shortened pulse appears. A first-stage code with no ratio assigned raises an error flag, and from the next period boundary the output stays low. The flag is combinational, so control logic can check a setting before the next edge.

Top module: `adc_clk_divider`

## Requirements
- R1: With `temp_mode`=0, `div1_sel` codes 0,1,2,3,4,5 give an output period of 1,2,10,20,40,80 input clock cycles. `stage_sel` and `div2_sel` have no effect in this mode.
- R2: When the first stage is in use and `div1_sel` is 6 or 7, `cfg_err` is 1. From the next period boundary `clk_out` stays low.
- R3: With `temp_mode`=1 and `stage_sel`=1, the output period is 10 input cycles when `div2_sel`=0 and 20 when it is 1. `div1_sel` is ignored, and `cfg_err` stays 0 even for codes 6 and 7.
- R4: With `temp_mode`=1 and `stage_sel`=0, the output period follows the `div1_sel` ratios of R1.
- R5: The output is high for exactly half of each period, starting at a rising edge of `clk_in`. For ratio 1, `clk_out` equals `clk_in`.
- R6: A change of any select or mode input takes effect only after the running output period has completed. No high pulse is shorter than the current ratio's half period.
- R7: A synchronous active-high `rst` forces `clk_out` low from the first clock edge at which it is sampled. At the first edge after release, a fresh period begins with the requested setting.
- R8: `cfg_err` reflects the current inputs in the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | PLL input clock |
| rst | input | 1 | Synchronous reset, active high |
| div1_sel | input | 3 | First-stage ratio code |
| div2_sel | input | 1 | Second-stage ratio: 0 gives /10, 1 gives /20 |
| temp_mode | input | 1 | 1 selects temperature sensing, 0 selects normal conversion |
| stage_sel | input | 1 | In temperature sensing: 0 selects the first stage, 1 selects the second |
| clk_out | output | 1 | Divided sampling clock |
| cfg_err | output | 1 | Illegal first-stage code in use |

## Verification
The error flag is due in the same cycle as the input change, so the bench checks it one time unit after driving. A new ratio is due only at the next period boundary. The bench therefore lets every setting settle for longer than the longest period before it measures. Measurement samples `clk_out` a quarter period after each input edge and derives the high time and the period from the sampled runs. The boundary tests change the setting just after a rising edge and expect the full old period before the new one begins. In the reset test, low is expected at the quarter point after the first sampled reset edge, and high at the first edge after release.

// File: rtl/adc_clk_divider.sv
module adc_clk_divider #(
  parameter int RW = 7
) (
  input  logic       clk_in,
  input  logic       rst,
  input  logic [2:0] div1_sel,
  input  logic       div2_sel,
  input  logic       temp_mode,
  input  logic       stage_sel,
  output logic       clk_out,
  output logic       cfg_err
);

  localparam logic [RW-1:0] ONE = RW'(1);

  function automatic logic [RW-1:0] first_ratio(input logic [2:0] code);
    case (code)
      3'd0:    first_ratio = RW'(1);
      3'd1:    first_ratio = RW'(2);
      3'd2:    first_ratio = RW'(10);
      3'd3:    first_ratio = RW'(20);
      3'd4:    first_ratio = RW'(40);
      3'd5:    first_ratio = RW'(80);
      default: first_ratio = '0;
    endcase
  endfunction

  logic          use_second;
  logic [RW-1:0] req_ratio;
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt_q;
  logic [RW-1:0] cnt_nxt;
  logic          phase_q;
  logic          bnd;

  assign use_second = temp_mode & stage_sel;
  assign req_ratio  = use_second ? (div2_sel ? RW'(20) : RW'(10)) : first_ratio(div1_sel);
  assign cfg_err    = !use_second && (div1_sel > 3'd5);

  assign cnt_nxt = cnt_q + ONE;
  assign bnd     = (ratio_q <= ONE) || (cnt_q == ratio_q - ONE);

  always_ff @(posedge clk_in) begin
    if (rst) begin
      ratio_q <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (bnd) begin
      ratio_q <= req_ratio;
      cnt_q   <= '0;
      phase_q <= req_ratio > ONE;
    end else begin
      cnt_q   <= cnt_nxt;
      phase_q <= cnt_nxt < (ratio_q >> 1);
    end
  end

  assign clk_out = (ratio_q == ONE) ? clk_in : phase_q;

endmodule

// File: rtl/adc_clk_divider_chk.sv
module adc_clk_divider_chk #(
  parameter int RW = 7
) (
  input logic          clk_in,
  input logic          rst,
  input logic          temp_mode,
  input logic          stage_sel,
  input logic          cfg_err,
  input logic          clk_out,
  input logic          bnd,
  input logic          phase_q,
  input logic [RW-1:0] ratio_q
);

  logic [RW-1:0] hi_len;

  always_ff @(posedge clk_in) begin
    if (rst || !phase_q) hi_len <= '0;
    else                 hi_len <= hi_len + RW'(1);
  end

  // R2
  err_park_chk: assert property (@(posedge clk_in) disable iff (rst)
    (cfg_err && bnd) |=> !clk_out);

  // R1
  ratio_legal_chk: assert property (@(posedge clk_in) disable iff (rst)
    (ratio_q == 0 || ratio_q == 1 || ratio_q == 2 || ratio_q == 10 ||
     ratio_q == 20 || ratio_q == 40 || ratio_q == 80));

  // R6
  hold_mid_chk: assert property (@(posedge clk_in) disable iff (rst)
    !bnd |=> $stable(ratio_q));

  // R3
  second_stage_chk: assert property (@(posedge clk_in) disable iff (rst)
    (temp_mode && stage_sel && bnd) |=> (ratio_q == 10 || ratio_q == 20));

  // R5
  duty_half_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!phase_q && $past(phase_q) && !$past(rst)) |-> (hi_len == (ratio_q >> 1)));

endmodule

bind adc_clk_divider adc_clk_divider_chk #(.RW(RW)) u_chk (
  .clk_in(clk_in), .rst(rst), .temp_mode(temp_mode), .stage_sel(stage_sel),
  .cfg_err(cfg_err), .clk_out(clk_out), .bnd(bnd), .phase_q(phase_q),
  .ratio_q(ratio_q)
);

// File: tb/test_adc_clk_divider.sv
module test_adc_clk_divider;
  localparam int PERIOD = 8;
  localparam int NS = 400;

  logic       clk_in = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] div1_sel = 3'd2;
  logic       div2_sel = 1'b0;
  logic       temp_mode = 1'b0;
  logic       stage_sel = 1'b0;
  logic       clk_out;
  logic       cfg_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int runt_bad = 0;

  always #(PERIOD/2) clk_in = ~clk_in;

  adc_clk_divider i_adc_clk_divider (
    .clk_in(clk_in), .rst(rst), .div1_sel(div1_sel), .div2_sel(div2_sel),
    .temp_mode(temp_mode), .stage_sel(stage_sel), .clk_out(clk_out), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic half();
    @(clk_in);
    #(PERIOD/4);
  endtask

  task automatic at_pos();
    @(posedge clk_in);
    #(PERIOD/4);
  endtask

  function automatic int exp_ratio(input bit t, input bit st, input bit d2, input int d1);
    if (t && st) return d2 ? 20 : 10;
    if (d1 > 5) return 0;
    if (d1 < 2) return d1 + 1;
    return 10 << (d1 - 2);
  endfunction

  // R6: any high run seen outside reset must match a legal ratio's half period
  int hi_run = 0;
  bit run_clean = 0;
  logic prev_s = 1'b0;
  initial begin
    forever begin
      half();
      if (rst) begin
        hi_run = 0;
        run_clean = 0;
      end else if (clk_out) begin
        if (!prev_s) begin hi_run = 0; run_clean = 1; end
        hi_run++;
      end else if (prev_s && run_clean) begin
        if (!(hi_run == 1 || hi_run == 2 || hi_run == 10 || hi_run == 20 ||
              hi_run == 40 || hi_run == 80)) runt_bad++;
      end
      prev_s = clk_out;
    end
  end

  task automatic measure(input int r, input string req);
    logic s [NS];
    int i1, i2, h;
    for (int k = 0; k < NS; k++) begin
      half();
      s[k] = clk_out;
    end
    if (r == 0) begin
      h = 0;
      for (int k = 0; k < NS; k++) if (s[k]) h++;
      check(h == 0, req, h, 0);
      return;
    end
    i1 = -1; i2 = -1;
    for (int k = 1; k < NS; k++) begin
      if (!s[k-1] && s[k]) begin
        if (i1 < 0) i1 = k;
        else if (i2 < 0) i2 = k;
      end
    end
    h = 0;
    if (i1 > 0) for (int k = i1; k < NS && s[k]; k++) h++;
    check(i1 > 0 && i2 > 0 && (i2 - i1) == 2 * r && h == r, req,
          (i2 - i1) * 1000 + h, 2 * r * 1000 + r);
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R7: reset holds the output low
    for (int k = 0; k < 4; k++) begin
      at_pos();
      check(clk_out == 1'b0, "R7 reset low", clk_out, 0);
    end
    rst = 1'b0;
    at_pos();
    check(clk_out == 1'b1, "R7 fresh period after release", clk_out, 1);

    // Sweep every configuration: R1, R2, R3, R4, R5, R8
    for (int t = 0; t < 2; t++)
      for (int st = 0; st < 2; st++)
        for (int d2 = 0; d2 < 2; d2++)
          for (int d1 = 0; d1 < 8; d1++) begin
            int r;
            string tag;
            temp_mode = t[0]; stage_sel = st[0]; div2_sel = d2[0]; div1_sel = d1[2:0];
            r = exp_ratio(t[0], st[0], d2[0], d1);
            #1;
            check(cfg_err == (r == 0), "R8 error flag immediate", cfg_err, r == 0);
            repeat (200) half();
            if (t == 1 && st == 1) tag = "R3 second stage";
            else if (t == 1) tag = "R4 first stage in temp mode";
            else if (r == 0) tag = "R2 invalid code parks low";
            else tag = "R1 R5 normal ratio and duty";
            measure(r, tag);
          end

    // R6: change mid-period, old period completes first
    begin
      logic s [60];
      logic p;
      int mism;
      temp_mode = 0; stage_sel = 0; div2_sel = 0; div1_sel = 3'd3;
      repeat (200) half();
      p = clk_out;
      forever begin
        half();
        if (!p && clk_out) break;
        p = clk_out;
      end
      div1_sel = 3'd2;
      for (int k = 0; k < 59; k++) begin half(); s[k] = clk_out; end
      mism = 0;
      for (int k = 0; k < 59; k++) begin
        logic e;
        e = (k < 19) ? 1'b1 : (k < 39) ? 1'b0 : (k < 49) ? 1'b1 : 1'b0;
        if (s[k] !== e) mism++;
      end
      check(mism == 0, "R6 ratio change waits for boundary", mism, 0);
    end

    // R6 with R2: switch to an invalid code mid-period
    begin
      logic p;
      int hi;
      int lo;
      div1_sel = 3'd4;
      repeat (200) half();
      p = clk_out;
      forever begin
        half();
        if (!p && clk_out) break;
        p = clk_out;
      end
      div1_sel = 3'd7;
      hi = 1; lo = 0;
      for (int k = 0; k < 300; k++) begin
        half();
        if (clk_out) hi++; else lo++;
      end
      check(hi == 40, "R6 R2 old period completes then low", hi, 40);
    end

    // R5: ratio 1 follows the input clock at both phases
    div1_sel = 3'd0;
    repeat (200) half();
    for (int k = 0; k < 4; k++) begin
      half();
      check(clk_out == clk_in, "R5 bypass follows input", clk_out, clk_in);
    end

    // R7: reset during a running period
    div1_sel = 3'd4;
    repeat (200) half();
    at_pos();
    rst = 1'b1;
    at_pos();
    check(clk_out == 1'b0, "R7 reset mid-run", clk_out, 0);
    rst = 1'b0;
    repeat (4) at_pos();

    check(runt_bad == 0, "R6 no runt pulse", runt_bad, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule